// File: doc/BRIEF.md
# Signaling Change Event Queue with Interrupt Flags

This block collects receive signaling change events and holds them in order until a host processor drains them. Each event carries a channel number and the new signaling bits, and is written with a single-cycle strobe. The oldest stored event is always presented on a pop port. A pop strobe removes it.

Three sticky interrupt flags track how the queue is doing. The depth flag sets when the fill level goes above a programmable threshold. The waiting flag sets when entries have sat unserviced for a programmable number of clocks. The overflow flag sets when an event arrives while the queue is full; that event and everything already stored are thrown away.

The host reaches a flag register, a mask register, the threshold and the waiting period through a small synchronous register port. A single active-high interrupt line is raised by any flag whose mask bit is 0. A configuration input selects how flags are cleared: either reading the flag register clears them, or writing 1 to a flag clears it.

Top module: `cos_event_queue`

## Requirements
- R1: Events leave the pop port in the order they were written. `pop_valid` is 1 whenever at least one entry is stored, and `pop_chan`/`pop_bits` show the oldest entry. A push and a pop in the same cycle are both honoured. A pop while the queue is empty is ignored.
- R2: After reset the queue is empty, all flags are 0, the mask reads 0x0007, the threshold reads 16, the period reads 100 and `irq` is 0.
- R3: An event written while 32 entries are stored, with no pop in that cycle, sets flag bit 0 (overflow) and leaves the queue empty; that event is not stored. Events written afterwards are stored normally.
- R4: Flag bit 2 (depth) sets one cycle after the stored count is greater than the threshold. A count equal to the threshold does not set it.
- R5: Flag bit 1 (waiting) sets when entries have stayed unpopped for `period` clocks; with the period at 5 it appears on the fifth edge after a push into an empty queue. An empty queue never sets it, each pop restarts the count, and a period of 0 disables it.
- R6: With `cfg_cor` = 1, a cycle with `reg_rd` at address 0 returns the flags and clears them at that edge.
- R7: With `cfg_cor` = 0, reading address 0 leaves the flags unchanged, and writing address 0 clears exactly the flags whose data bit is 1. With `cfg_cor` = 1, writes to address 0 have no effect.
- R8: A flag whose set condition is true in the same cycle as a clearing access stays set.
- R9: A flag that is set stays set until it is cleared, even after its condition goes away.
- R10: `irq` is 1 exactly when some flag is 1 and its mask bit is 0. Mask bit 2 gates depth, bit 1 gates waiting, bit 0 gates overflow.
- R11: The register map is: address 0 = flags (bits 2:0), address 1 = mask (bits 2:0), address 2 = threshold (bits 5:0), address 3 = period (bits 15:0). `reg_rdata` always shows the register selected by `reg_addr`. All bits not listed read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Event write strobe |
| evt_chan | input | 5 | Channel number of the event |
| evt_bits | input | 4 | New signaling bits of the event |
| pop_req | input | 1 | Remove the oldest entry |
| pop_valid | output | 1 | At least one entry is stored |
| pop_chan | output | 5 | Channel of the oldest entry |
| pop_bits | output | 4 | Signaling bits of the oldest entry |
| cfg_cor | input | 1 | 1: reading the flags clears them; 0: flags are cleared by writing 1 |
| reg_rd | input | 1 | Register read strobe (only matters for clearing) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The bench fills the queue to exactly 32 entries and then writes one more. A design that flags overflow one entry too early, or that keeps the stale entries, is caught at the pop port. It holds the stored count equal to the threshold and then one above it, which exposes an off-by-one comparison. It also issues a clearing read while the depth condition is still true; a design where the clear wins would lose that flag. The waiting flag is checked on both sides of its expiry edge, with an empty queue, and with the period set to 0. Finally, each clear mode is exercised against the wrong access type, which exposes a read that clears when it must not or a write that clears when it must not.

// File: rtl/cosq_pkg.sv
package cosq_pkg;
    localparam int CH_W   = 5;
    localparam int SIG_W  = 4;
    localparam int REG_W  = 16;
    localparam int FLAG_N = 3;

    localparam int F_DEPTH = 2;
    localparam int F_WAIT  = 1;
    localparam int F_OVF   = 0;

    typedef struct packed {
        logic [CH_W-1:0]  chan;
        logic [SIG_W-1:0] bits;
    } cos_evt_t;

    typedef enum logic [1:0] {
        A_FLAGS  = 2'd0,
        A_MASK   = 2'd1,
        A_THRESH = 2'd2,
        A_PERIOD = 2'd3
    } reg_addr_e;

    function automatic logic [REG_W-1:0] pad_flags(input logic [FLAG_N-1:0] f);
        return REG_W'(f);
    endfunction
endpackage

// File: rtl/cosq_store.sv
module cosq_store
    import cosq_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  cos_evt_t         push_data,
    input  logic             pop_req,
    output cos_evt_t         head,
    output logic [CNT_W-1:0] fill,
    output logic             pop_fire,
    output logic             ovf
);
    cos_evt_t         mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             empty, full, push_ok;

    assign empty    = (fill == '0);
    assign full     = (fill == CNT_W'(DEPTH));
    assign pop_fire = pop_req && !empty;
    assign push_ok  = push && (!full || pop_fire);
    assign ovf      = push && full && !pop_fire;
    assign head     = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || ovf) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push_ok)  wr_ptr <= bump(wr_ptr);
            if (pop_fire) rd_ptr <= bump(rd_ptr);
            fill <= fill + CNT_W'(push_ok) - CNT_W'(pop_fire);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end
endmodule

// File: rtl/cosq_timer.sv
module cosq_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [TMR_W-1:0] period,
    output logic             expire
);
    logic [TMR_W-1:0] ticks;
    logic             enabled;

    assign enabled = (period != '0);
    assign expire  = enabled && !restart && (ticks >= period - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || restart || !enabled || expire) begin
            ticks <= '0;
        end else begin
            ticks <= ticks + 1'b1;
        end
    end
endmodule

// File: rtl/cosq_regs.sv
module cosq_regs
    import cosq_pkg::*;
#(
    parameter int THR_W   = 6,
    parameter int TMR_W   = 16,
    parameter int THR_RST = 16,
    parameter int PER_RST = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_cor,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic [FLAG_N-1:0] flag_set,
    output logic [FLAG_N-1:0] flags,
    output logic [FLAG_N-1:0] mask,
    output logic [THR_W-1:0]  thresh,
    output logic [TMR_W-1:0]  period,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq
);
    reg_addr_e         sel;
    logic [FLAG_N-1:0] flag_clr;
    logic              hit_flags;

    assign sel       = reg_addr_e'(reg_addr);
    assign hit_flags = (sel == A_FLAGS);

    always_comb begin
        flag_clr = '0;
        if (cfg_cor) begin
            if (reg_rd && hit_flags) flag_clr = '1;
        end else begin
            if (reg_wr && hit_flags) flag_clr = reg_wdata[FLAG_N-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags  <= '0;
            mask   <= '1;
            thresh <= THR_W'(THR_RST);
            period <= TMR_W'(PER_RST);
        end else begin
            flags <= (flags & ~flag_clr) | flag_set;
            if (reg_wr) begin
                case (sel)
                    A_MASK:   mask   <= reg_wdata[FLAG_N-1:0];
                    A_THRESH: thresh <= reg_wdata[THR_W-1:0];
                    A_PERIOD: period <= reg_wdata[TMR_W-1:0];
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        case (sel)
            A_FLAGS:  reg_rdata = pad_flags(flags);
            A_MASK:   reg_rdata = pad_flags(mask);
            A_THRESH: reg_rdata = REG_W'(thresh);
            A_PERIOD: reg_rdata = REG_W'(period);
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = |(flags & ~mask);
endmodule

// File: rtl/cos_event_queue.sv
module cos_event_queue
    import cosq_pkg::*;
#(
    parameter int DEPTH   = 32,
    parameter int TMR_W   = 16,
    parameter int THR_RST = 16,
    parameter int PER_RST = 100,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int THR_W  = CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_valid,
    input  logic [CH_W-1:0]  evt_chan,
    input  logic [SIG_W-1:0] evt_bits,
    input  logic             pop_req,
    output logic             pop_valid,
    output logic [CH_W-1:0]  pop_chan,
    output logic [SIG_W-1:0] pop_bits,
    input  logic             cfg_cor,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq
);
    cos_evt_t          in_evt, head;
    logic [CNT_W-1:0]  fill;
    logic              pop_fire, ovf, expire;
    logic [FLAG_N-1:0] flag_set, status_q, mask_q;
    logic [THR_W-1:0]  thr_q;
    logic [TMR_W-1:0]  per_q;

    assign in_evt = '{chan: evt_chan, bits: evt_bits};

    cosq_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .push      (evt_valid),
        .push_data (in_evt),
        .pop_req   (pop_req),
        .head      (head),
        .fill      (fill),
        .pop_fire  (pop_fire),
        .ovf       (ovf)
    );

    cosq_timer #(.TMR_W(TMR_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart ((fill == '0) || pop_fire),
        .period  (per_q),
        .expire  (expire)
    );

    always_comb begin
        flag_set          = '0;
        flag_set[F_DEPTH] = (fill > thr_q);
        flag_set[F_WAIT]  = expire;
        flag_set[F_OVF]   = ovf;
    end

    cosq_regs #(
        .THR_W   (THR_W),
        .TMR_W   (TMR_W),
        .THR_RST (THR_RST),
        .PER_RST (PER_RST)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_cor   (cfg_cor),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .flag_set  (flag_set),
        .flags     (status_q),
        .mask      (mask_q),
        .thresh    (thr_q),
        .period    (per_q),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    assign pop_valid = (fill != '0);
    assign pop_chan  = head.chan;
    assign pop_bits  = head.bits;
endmodule

// File: rtl/cosq_checker.sv
module cosq_checker #(
    parameter int DEPTH = 32,
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             evt_valid,
    input logic             pop_req,
    input logic             cfg_cor,
    input logic             reg_rd,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic             irq,
    input logic [2:0]       status,
    input logic [2:0]       mask,
    input logic [CNT_W-1:0] fill,
    input logic [CNT_W-1:0] thr
);
    assert_reset_state_R2: assert property (@(posedge clk)
        $past(rst) |-> (status == 3'b000 && mask == 3'b111 && fill == '0));

    assert_overflow_flush_R3: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && fill == CNT_W'(DEPTH) && !pop_req) |=> (fill == '0 && status[0]));

    assert_depth_flag_R4: assert property (@(posedge clk) disable iff (rst)
        (fill > thr) |=> status[2]);

    assert_empty_no_wait_R5: assert property (@(posedge clk) disable iff (rst)
        (fill == '0 && !status[1]) |=> !status[1]);

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && cfg_cor && reg_addr == 2'd0 && fill == '0) |=> (status == 3'b000));

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && cfg_cor && reg_addr == 2'd0 && fill > thr) |=> status[2]);

    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (!reg_rd && !reg_wr) |=> ((status & $past(status)) == $past(status)));

    assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (mask == 3'b111 || status == 3'b000) |-> !irq);
endmodule

bind cos_event_queue cosq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_cosq_checker (
    .clk       (clk),
    .rst       (rst),
    .evt_valid (evt_valid),
    .pop_req   (pop_req),
    .cfg_cor   (cfg_cor),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .irq       (irq),
    .status    (status_q),
    .mask      (mask_q),
    .fill      (fill),
    .thr       (thr_q)
);

// File: tb/cos_event_queue_bench.sv
module cos_event_queue_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt_valid = 1'b0;
    logic [4:0]  evt_chan = '0;
    logic [3:0]  evt_bits = '0;
    logic        pop_req = 1'b0;
    logic        pop_valid;
    logic [4:0]  pop_chan;
    logic [3:0]  pop_bits;
    logic        cfg_cor = 1'b1;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    logic [15:0] got;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cos_event_queue u_cos_event_queue (
        .clk, .rst, .evt_valid, .evt_chan, .evt_bits, .pop_req,
        .pop_valid, .pop_chan, .pop_bits, .cfg_cor, .reg_rd, .reg_wr,
        .reg_addr, .reg_wdata, .reg_rdata, .irq
    );

    typedef struct packed {
        logic       push;
        logic       pop;
        logic [4:0] ch;
        logic [3:0] sb;
        logic       ev;
        logic [4:0] ech;
        logic [3:0] esb;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 1'b0, 5'd1, 4'hA, 1'b1, 5'd1, 4'hA},
        '{1'b1, 1'b0, 5'd2, 4'h5, 1'b1, 5'd1, 4'hA},
        '{1'b1, 1'b0, 5'd3, 4'hF, 1'b1, 5'd1, 4'hA},
        '{1'b0, 1'b1, 5'd0, 4'h0, 1'b1, 5'd2, 4'h5},
        '{1'b1, 1'b1, 5'd4, 4'h3, 1'b1, 5'd3, 4'hF},
        '{1'b0, 1'b1, 5'd0, 4'h0, 1'b1, 5'd4, 4'h3},
        '{1'b0, 1'b1, 5'd0, 4'h0, 1'b0, 5'd0, 4'h0},
        '{1'b0, 1'b1, 5'd0, 4'h0, 1'b0, 5'd0, 4'h0},
        '{1'b1, 1'b0, 5'd7, 4'h9, 1'b1, 5'd7, 4'h9},
        '{1'b0, 1'b1, 5'd0, 4'h0, 1'b0, 5'd0, 4'h0}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic peek(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1;
        d = reg_rdata;
        cyc();
        reg_rd = 1'b0;
    endtask

    task automatic push(input logic [4:0] c, input logic [3:0] b);
        evt_valid = 1'b1; evt_chan = c; evt_bits = b;
        cyc();
        evt_valid = 1'b0;
    endtask

    task automatic pop();
        pop_req = 1'b1;
        cyc();
        pop_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        report();
    end

    initial begin
        repeat (3) cyc();
        rst = 1'b0;

        // R2 reset state
        chk("R2 pop_valid", 16'(pop_valid), 16'h0);
        chk("R2 irq", 16'(irq), 16'h0);
        peek(2'd0, got); chk("R2 flags", got, 16'h0000);
        peek(2'd1, got); chk("R2 mask", got, 16'h0007);
        peek(2'd2, got); chk("R2 thresh", got, 16'd16);
        peek(2'd3, got); chk("R2 period", got, 16'd100);

        // R11 field widths
        wr(2'd2, 16'hFFFF); peek(2'd2, got); chk("R11 thresh width", got, 16'h003F);
        wr(2'd1, 16'hFFFF); peek(2'd1, got); chk("R11 mask width", got, 16'h0007);
        wr(2'd3, 16'h1234); peek(2'd3, got); chk("R11 period", got, 16'h1234);
        wr(2'd2, 16'd16);
        wr(2'd3, 16'd100);

        // R1 ordering table
        for (int i = 0; i < NVEC; i++) begin
            evt_valid = VEC[i].push; evt_chan = VEC[i].ch; evt_bits = VEC[i].sb;
            pop_req   = VEC[i].pop;
            cyc();
            evt_valid = 1'b0; pop_req = 1'b0;
            chk("R1 valid", 16'(pop_valid), 16'(VEC[i].ev));
            if (VEC[i].ev) begin
                chk("R1 chan", 16'(pop_chan), 16'(VEC[i].ech));
                chk("R1 bits", 16'(pop_bits), 16'(VEC[i].esb));
            end
        end

        // R4 depth threshold, R10 masking, R8, R9, R6
        wr(2'd3, 16'd0);
        wr(2'd2, 16'd2);
        push(5'd10, 4'h1);
        push(5'd11, 4'h2);
        cyc();
        peek(2'd0, got); chk("R4 count equal to threshold", got, 16'h0000);
        push(5'd12, 4'h3);
        cyc();
        peek(2'd0, got); chk("R4 count above threshold", got, 16'h0004);
        chk("R10 all masked", 16'(irq), 16'h0);
        wr(2'd1, 16'h0003); chk("R10 depth unmasked", 16'(irq), 16'h1);
        wr(2'd1, 16'h0004); chk("R10 depth masked", 16'(irq), 16'h0);
        wr(2'd1, 16'h0007);
        rd(2'd0, got); chk("R6 read data", got, 16'h0004);
        peek(2'd0, got); chk("R8 set beats clear", got, 16'h0004);
        wr(2'd2, 16'd32);
        cyc();
        peek(2'd0, got); chk("R9 sticky", got, 16'h0004);
        rd(2'd0, got);
        peek(2'd0, got); chk("R6 cleared by read", got, 16'h0000);
        repeat (150) cyc();
        peek(2'd0, got); chk("R5 period zero disables", got, 16'h0000);
        pop(); pop(); pop();
        chk("R1 drained", 16'(pop_valid), 16'h0);

        // R5 waiting timer
        wr(2'd3, 16'd5);
        repeat (20) cyc();
        peek(2'd0, got); chk("R5 empty queue", got, 16'h0000);
        push(5'd20, 4'h7);
        repeat (4) cyc();
        peek(2'd0, got); chk("R5 before expiry", got, 16'h0000);
        cyc();
        peek(2'd0, got); chk("R5 at expiry", got, 16'h0002);

        // R7 write-one-to-clear mode
        wr(2'd3, 16'd0);
        cfg_cor = 1'b0;
        rd(2'd0, got);
        peek(2'd0, got); chk("R7 read keeps flags", got, 16'h0002);
        wr(2'd0, 16'h0001);
        peek(2'd0, got); chk("R7 other bit write", got, 16'h0002);
        wr(2'd0, 16'h0002);
        peek(2'd0, got); chk("R7 write one clears", got, 16'h0000);
        cfg_cor = 1'b1;
        pop();

        // R3 overflow
        for (int i = 0; i < 32; i++) push(5'(i), 4'(i));
        peek(2'd0, got); chk("R4 full at threshold 32", got, 16'h0000);
        chk("R3 full valid", 16'(pop_valid), 16'h1);
        chk("R3 full head", 16'(pop_chan), 16'h0000);
        push(5'd31, 4'hE);
        chk("R3 flushed", 16'(pop_valid), 16'h0);
        peek(2'd0, got); chk("R3 overflow flag", got, 16'h0001);
        push(5'd9, 4'h6);
        chk("R3 after flush chan", 16'(pop_chan), 16'd9);
        chk("R3 after flush bits", 16'(pop_bits), 16'd6);
        wr(2'd1, 16'h0006); chk("R10 overflow unmasked", 16'(irq), 16'h1);
        wr(2'd0, 16'hFFFF);
        peek(2'd0, got); chk("R7 write ignored in read-clear mode", got, 16'h0001);
        rd(2'd0, got);
        peek(2'd0, got); chk("R6 overflow cleared", got, 16'h0000);
        chk("R10 irq low after clear", 16'(irq), 16'h0);

        report();
    end
endmodule